// File: doc/BRIEF.md
# Modulo Interval Timer with Guarded Overflow Flag

This block is a 16-bit up-counter clocked by a selectable power-of-two division of the system clock. Software programs a 16-bit wrap value through two byte registers. The counter runs from zero up to that value, returns to zero on the following tick, and sets an overflow flag as it does so. When the interrupt enable is set, the flag drives an interrupt request. A control bit stops the counter, and a self-clearing control bit zeroes both the counter and the divider.

Software can only clear the flag in two steps. First it reads the status/control register and sees the flag set. Then it writes 0 to the flag bit. If a new overflow happens after that read, the clearing write is ignored, so an overflow event cannot be lost. All registers sit on a byte-wide bus with an address, a read strobe and a write strobe. Reads return data combinationally within the strobe cycle.

Top module: `modtmr_top`

## Requirements
- R1: After reset the status/control register reads 0x20 (only the stop bit is set), the counter reads 0, the wrap value reads 0xFFFF and `irq` is low.
- R2: Register addresses are 0 for status/control, 1 for counter high byte, 2 for counter low byte, 3 for wrap value high byte and 4 for wrap value low byte. In status/control, bit 7 is the overflow flag, bit 6 the interrupt enable, bit 5 stop, bit 4 counter reset, bit 3 reserved and bits 2:0 the divider select.
- R3: While running, the counter advances by one per divided tick. On the tick where it equals the wrap value it goes to 0 instead, and the flag is set on that same clock edge.
- R4: With divider select S, one tick occurs every 2^S clocks. S = 7 behaves like S = 6, giving a divide by 64.
- R5: While stop is 1, the counter and the divider hold their values.
- R6: Writing 1 to bit 4 zeroes the counter and the divider on that write's clock edge. Bits 4 and 3 always read as 0.
- R7: A write of 0 to bit 7 clears the flag only if an earlier read of status/control saw the flag set. Any write to status/control consumes that arming, so a second write of 0 does not clear the flag.
- R8: An overflow that occurs after the arming read, including one in the same cycle as the clearing write, makes the clearing write leave the flag set.
- R9: Writing 1 to bit 7 never changes the flag.
- R10: `irq` is high exactly while both the flag and the interrupt enable are 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 3 | Register address |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid during the read strobe |
| irq | output | 1 | Overflow interrupt request |

## Verification
The hardest case to set up is an overflow that lands between the arming read and the clearing write. The bench reaches it by setting the wrap value to 0 at divide-by-1, so every clock is an overflow. The arming read and the write of 0 are then always separated by an overflow, and the flag must still read as set afterwards. A separate sequence is timed against a small wrap value, so that the read sees the flag and the clearing write falls on a tick that does not wrap. A third sequence stops the counter while it sits on its wrap value, so that the stopping write itself coincides with an overflow.

// File: rtl/modtmr_pkg.sv
package modtmr_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 3;
  localparam int CNT_W  = 16;
  localparam int PS_W   = 3;
  localparam int PRE_W  = 6;

  localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
  localparam logic [ADDR_W-1:0] A_CNT_H = 3'd1;
  localparam logic [ADDR_W-1:0] A_CNT_L = 3'd2;
  localparam logic [ADDR_W-1:0] A_MOD_H = 3'd3;
  localparam logic [ADDR_W-1:0] A_MOD_L = 3'd4;

  localparam int B_FLAG = 7;
  localparam int B_IE   = 6;
  localparam int B_STOP = 5;
  localparam int B_CLR  = 4;

  typedef struct packed {
    logic            ie;
    logic            stop;
    logic [PS_W-1:0] ps;
  } ctrl_t;
endpackage

// File: rtl/modtmr_presc.sv
module modtmr_presc #(
  parameter int PRE_W = 6,
  parameter int PS_W  = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            clr,
  input  logic [PS_W-1:0] ps,
  output logic            tick
);
  localparam logic [PS_W-1:0] PS_TOP = PS_W'(PRE_W);

  logic [PRE_W-1:0] pre_q, pre_d;
  logic [PS_W-1:0]  eff;
  logic [PRE_W-1:0] mask;

  always_comb begin
    eff  = (ps > PS_TOP) ? PS_TOP : ps;
    mask = ~({PRE_W{1'b1}} << eff);
    tick = run && ((pre_q & mask) == mask);
    if (clr)      pre_d = '0;
    else if (run) pre_d = pre_q + 1'b1;
    else          pre_d = pre_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end
endmodule

// File: rtl/modtmr_cnt.sv
module modtmr_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             clr,
  input  logic [CNT_W-1:0] modv,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    wrap = tick && !clr && (cnt == modv);
    if (clr || wrap) cnt_d = '0;
    else if (tick)   cnt_d = cnt + 1'b1;
    else             cnt_d = cnt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_d;
  end
endmodule

// File: rtl/modtmr_regs.sv
module modtmr_regs
  import modtmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              wrap,
  output logic [DATA_W-1:0] rdata,
  output ctrl_t             ctrl,
  output logic              clr_pulse,
  output logic [CNT_W-1:0]  modv,
  output logic              flag,
  output logic              irq
);
  ctrl_t            ctrl_d;
  logic [CNT_W-1:0] modv_d;
  logic             flag_d, armed_q, armed_d;
  logic             ctrl_wr, ctrl_rd;

  always_comb begin
    ctrl_wr   = wr_en && (addr == A_CTRL);
    ctrl_rd   = rd_en && (addr == A_CTRL);
    clr_pulse = ctrl_wr && wdata[B_CLR];

    ctrl_d = ctrl;
    if (ctrl_wr) begin
      ctrl_d.ie   = wdata[B_IE];
      ctrl_d.stop = wdata[B_STOP];
      ctrl_d.ps   = wdata[PS_W-1:0];
    end

    modv_d = modv;
    if (wr_en && addr == A_MOD_H) modv_d[CNT_W-1:DATA_W] = wdata;
    if (wr_en && addr == A_MOD_L) modv_d[DATA_W-1:0]     = wdata;

    // overflow wins over a clear and cancels any pending arming
    if (wrap)                                 flag_d = 1'b1;
    else if (ctrl_wr && armed_q && !wdata[B_FLAG]) flag_d = 1'b0;
    else                                      flag_d = flag;

    if (wrap || ctrl_wr)     armed_d = 1'b0;
    else if (ctrl_rd && flag) armed_d = 1'b1;
    else                      armed_d = armed_q;

    irq = flag && ctrl.ie;

    unique case (addr)
      A_CTRL:  rdata = {flag, ctrl.ie, ctrl.stop, 2'b00, ctrl.ps};
      A_CNT_H: rdata = cnt[CNT_W-1:DATA_W];
      A_CNT_L: rdata = cnt[DATA_W-1:0];
      A_MOD_H: rdata = modv[CNT_W-1:DATA_W];
      A_MOD_L: rdata = modv[DATA_W-1:0];
      default: rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl    <= '{ie: 1'b0, stop: 1'b1, ps: '0};
      modv    <= '1;
      flag    <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      ctrl    <= ctrl_d;
      modv    <= modv_d;
      flag    <= flag_d;
      armed_q <= armed_d;
    end
  end
endmodule

// File: rtl/modtmr_top.sv
module modtmr_top
  import modtmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);
  logic             rs0, rst_s;
  ctrl_t            ctrl;
  logic             clr_pulse, tick, wrap, flag;
  logic [CNT_W-1:0] modv, count;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {rst_s, rs0} <= 2'b00;
    else        {rst_s, rs0} <= {rs0, 1'b1};
  end

  modtmr_presc #(.PRE_W(PRE_W), .PS_W(PS_W)) u_presc (
    .clk(clk), .rst_n(rst_s), .run(!ctrl.stop), .clr(clr_pulse),
    .ps(ctrl.ps), .tick(tick)
  );

  modtmr_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_s), .tick(tick), .clr(clr_pulse),
    .modv(modv), .cnt(count), .wrap(wrap)
  );

  modtmr_regs u_regs (
    .clk(clk), .rst_n(rst_s), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
    .wdata(wdata), .cnt(count), .wrap(wrap), .rdata(rdata), .ctrl(ctrl),
    .clr_pulse(clr_pulse), .modv(modv), .flag(flag), .irq(irq)
  );
endmodule

// File: rtl/modtmr_chk.sv
module modtmr_chk
  import modtmr_pkg::*;
(
  input logic              clk,
  input logic              rst_s,
  input logic [ADDR_W-1:0] addr,
  input logic              rd_en,
  input logic              wr_en,
  input logic [DATA_W-1:0] wdata,
  input logic [DATA_W-1:0] rdata,
  input logic              irq,
  input logic              flag,
  input logic              ie,
  input logic              stop,
  input logic              wrap,
  input logic [CNT_W-1:0]  count
);
  assert_wrap_zero_R3: assert property (@(posedge clk) disable iff (!rst_s)
    wrap |=> (count == '0));

  assert_wrap_sets_flag_R8: assert property (@(posedge clk) disable iff (!rst_s)
    wrap |=> flag);

  assert_flag_falls_on_write_R7: assert property (@(posedge clk) disable iff (!rst_s)
    $fell(flag) |-> $past(wr_en && addr == A_CTRL && !wdata[B_FLAG]));

  assert_stop_holds_R5: assert property (@(posedge clk) disable iff (!rst_s)
    (stop && !(wr_en && addr == A_CTRL)) |=> $stable(count));

  assert_irq_follows_R10: assert property (@(posedge clk) disable iff (!rst_s)
    (wrap && ie && !(wr_en && addr == A_CTRL)) |=> irq);

  assert_quiet_bits_R6: assert property (@(posedge clk) disable iff (!rst_s)
    (rd_en && addr == A_CTRL) |-> (rdata[4:3] == 2'b00));
endmodule

bind modtmr_top modtmr_chk u_chk (
  .clk(clk), .rst_s(rst_s), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
  .wdata(wdata), .rdata(rdata), .irq(irq), .flag(flag), .ie(ctrl.ie),
  .stop(ctrl.stop), .wrap(wrap), .count(count)
);

// File: tb/test_modtmr_top.sv
`timescale 1ns/1ps
module test_modtmr_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] addr = '0;
  logic       rd_en = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       irq;

  int n_cmp = 0;
  int n_bad = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  bit         done = 1'b0;

  always #5 clk = ~clk;

  modtmr_top i_modtmr_top (
    .clk(clk), .rst_n(rst_n), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
    .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  // monitor: compares each read against the head of the scoreboard
  always @(negedge clk) begin
    if (rd_en && exp_q.size() > 0) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_cmp++;
      if (rdata !== e) begin
        n_bad++;
        $display("FAIL %s: rdata=%02h expected=%02h", t, rdata, e);
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] e, input string t);
    exp_q.push_back(e); tag_q.push_back(t);
    addr = a; rd_en = 1'b1;
    @(posedge clk); #1;
    rd_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk_irq(input logic e, input string t);
    @(negedge clk);
    n_cmp++;
    if (irq !== e) begin
      n_bad++;
      $display("FAIL %s: irq=%0b expected=%0b", t, irq, e);
    end
    @(posedge clk); #1;
  endtask

  initial begin
    fork
      begin
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        idle(4);

        // R1 reset values
        rd(3'd0, 8'h20, "R1 ctrl");
        rd(3'd1, 8'h00, "R1 cnt hi");
        rd(3'd2, 8'h00, "R1 cnt lo");
        rd(3'd3, 8'hFF, "R1 mod hi");
        rd(3'd4, 8'hFF, "R1 mod lo");
        chk_irq(1'b0, "R1 irq");
        idle(5);
        rd(3'd2, 8'h00, "R5 stopped after reset");

        // R3 counting, wrap and timed clear (R7)
        wr(3'd3, 8'h00);
        wr(3'd4, 8'h05);
        rd(3'd3, 8'h00, "R2 mod hi readback");
        wr(3'd0, 8'h10);
        rd(3'd2, 8'h00, "R6 cleared");
        rd(3'd2, 8'h01, "R3 count 1");
        rd(3'd2, 8'h02, "R3 count 2");
        rd(3'd0, 8'h00, "R3 no flag yet");
        rd(3'd2, 8'h04, "R3 count 4");
        rd(3'd0, 8'h00, "R3 no flag at modulo");
        rd(3'd0, 8'h80, "R3 flag after wrap");
        wr(3'd0, 8'h00);
        rd(3'd0, 8'h00, "R7 armed clear");
        rd(3'd2, 8'h03, "R3 count after wrap");

        // R8 overflow every clock cancels clear
        wr(3'd0, 8'h30);
        wr(3'd4, 8'h00);
        wr(3'd0, 8'h10);
        idle(2);
        rd(3'd0, 8'h80, "R8 flag set");
        wr(3'd0, 8'h00);
        rd(3'd0, 8'h80, "R8 clear cancelled");
        wr(3'd0, 8'h20);
        rd(3'd0, 8'hA0, "R8 wrap on stopping write");

        // R9 / R7 arming rules
        wr(3'd0, 8'hA0);
        rd(3'd0, 8'hA0, "R9 write one ignored");
        wr(3'd0, 8'hA0);
        wr(3'd0, 8'h20);
        rd(3'd0, 8'hA0, "R7 arm consumed");
        wr(3'd0, 8'h20);
        rd(3'd0, 8'h20, "R7 clear");

        // R10 interrupt request
        wr(3'd0, 8'h60);
        chk_irq(1'b0, "R10 enable without flag");
        wr(3'd4, 8'h02);
        wr(3'd0, 8'h50);
        idle(4);
        chk_irq(1'b1, "R10 flag and enable");
        rd(3'd0, 8'hC0, "R10 ctrl");
        wr(3'd0, 8'h20);
        chk_irq(1'b0, "R10 enable dropped");

        // R4 divider
        wr(3'd4, 8'hFF);
        wr(3'd0, 8'h12);
        idle(40);
        rd(3'd2, 8'h0A, "R4 divide by 4");
        rd(3'd0, 8'h82, "R6 clear bit reads zero");
        wr(3'd0, 8'h17);
        idle(128);
        rd(3'd2, 8'h02, "R4 select 7 as 64");

        // R2 high byte, R5 stop, R6 clear while stopped
        wr(3'd3, 8'hFF);
        wr(3'd0, 8'h10);
        idle(300);
        rd(3'd1, 8'h01, "R2 cnt hi");
        rd(3'd2, 8'h2D, "R2 cnt lo");
        rd(3'd3, 8'hFF, "R2 mod hi");
        wr(3'd0, 8'h20);
        rd(3'd2, 8'h30, "R5 stopped value");
        idle(10);
        rd(3'd2, 8'h30, "R5 still held");
        wr(3'd0, 8'h30);
        rd(3'd2, 8'h00, "R6 clear while stopped");
        rd(3'd0, 8'h20, "R6 ctrl readback");
        idle(2);
      end
      begin
        repeat (20000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
      end
    join_any
    disable fork;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule